// File: doc/BRIEF.md
# Programmable Input Debounce Filter

This block cleans one asynchronous level before it reaches edge-event logic that timestamps transitions. It first brings the raw level into the module clock domain through a short flop chain. It then lets the filtered output follow that level only once the level has stayed at a new value for a programmed number of consecutive clock samples. Any excursion, high or low, that is shorter than this length is dropped and never shows at the output.

The length comes from a 3-bit code. Codes 0 to 6 select one to seven samples, and code 7 jumps to a long window of sixteen samples. The code is a plain input that is read on every clock, so it can be changed while the filter is running. A low enable parks the filter: the output is forced low and the stability count is cleared. After the enable returns, the output needs a full stable run before it can go high.

Top module: `lvl_debounce`

## Requirements
- R1: While `rst_n` is low, `clean_out` is 0 whatever the level of `raw_in`. The first rising clock edge after release treats the synchronised level as 0.
- R2: With `len_code` = c for c in 0..6, a new level on the synchronised input must be seen on c+1 consecutive clock samples before `clean_out` takes it. A run of c samples leaves `clean_out` unchanged.
- R3: With `len_code` = 7, the required run is 16 consecutive samples. A run of 15 samples is dropped.
- R4: A low excursion from a settled high output is filtered by the same rule as a high excursion from a settled low output. A sample that equals the current output restarts the run.
- R5: `raw_in` passes through two synchroniser flops. A level that `raw_in` presents at rising edge k is first counted at edge k+2. With code 0, `clean_out` takes it right after edge k+2.
- R6: While `en` is 0, `clean_out` is 0 from the next edge on and `raw_in` activity has no effect on it. After `en` returns to 1, a high input needs a full run (measured from the first enabled edge) before `clean_out` goes high.
- R7: A change of `len_code` takes effect at the next sample. If the run already counted is at least as long as the new length, `clean_out` flips at that next sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock; all sampling is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| en | input | 1 | Filter enable; 0 holds the output low and clears the count |
| raw_in | input | 1 | Unsynchronised level to be cleaned |
| len_code | input | 3 | Length code: 0..6 give 1..7 samples, 7 gives 16 samples |
| clean_out | output | 1 | Filtered, clock-domain level |

## Verification
The bench builds the filter with its default parameters: two synchroniser stages, a 3-bit length code and a 16-sample long window. These make all eight codes reachable, including the jump from seven samples to sixteen at code 7. The bench drives pulses one sample shorter than each length and pulses of exactly the length, in both polarities. It changes the code in the middle of a run to reach the case where the count already covers the new length. It also toggles the enable around settled levels and applies long stretches of random run lengths, with the code and enable changing as well.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  // Action taken by the stability counter on one sample.
  typedef enum logic [1:0] {
    ACT_PARK  = 2'd0,  // filter disabled: clear count, force output low
    ACT_MATCH = 2'd1,  // sample equals output: restart the run
    ACT_COUNT = 2'd2,  // sample differs, run still short: extend it
    ACT_FLIP  = 2'd3   // sample differs and run is long enough: take it
  } dbf_act_e;

  // Width needed to hold a count from 0 up to and including max_len.
  function automatic int unsigned cnt_width(input int unsigned max_len);
    return $clog2(max_len + 1);
  endfunction

endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // Each stage takes the one before it; stage 0 takes the raw level.
  always_comb begin
    chain_d[0] = d_async;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_link
      always_comb begin
        chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dbf_len_decode.sv
module dbf_len_decode #(
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned LONG_LEN = 16,
  parameter int unsigned CNT_W    = 5
) (
  input  logic [CODE_W-1:0] len_code,
  output logic [CNT_W-1:0]  run_len
);

  localparam int unsigned TOP_CODE = (1 << CODE_W) - 1;

  // The top code selects the long window; all other codes are code + 1.
  always_comb begin
    if (len_code == CODE_W'(TOP_CODE)) begin
      run_len = CNT_W'(LONG_LEN);
    end else begin
      run_len = CNT_W'(len_code) + CNT_W'(1);
    end
  end

endmodule

// File: rtl/dbf_stab_counter.sv
module dbf_stab_counter
  import dbf_pkg::*;
#(
  parameter int unsigned MAX_LEN = 16,
  parameter int unsigned CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             smp,
  input  logic [CNT_W-1:0] run_len,
  output logic             lvl
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_inc;
  dbf_act_e         act;

  assign cnt_inc = cnt_q + CNT_W'(1);

  // Decide what this sample does.
  always_comb begin
    if (!en) begin
      act = ACT_PARK;
    end else if (smp == lvl_q) begin
      act = ACT_MATCH;
    end else if (cnt_inc >= run_len) begin
      act = ACT_FLIP;
    end else begin
      act = ACT_COUNT;
    end
  end

  // Next state from the chosen action.
  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    unique case (act)
      ACT_PARK: begin
        cnt_d = '0;
        lvl_d = 1'b0;
      end
      ACT_MATCH: begin
        cnt_d = '0;
      end
      ACT_COUNT: begin
        cnt_d = cnt_inc;
      end
      ACT_FLIP: begin
        cnt_d = '0;
        lvl_d = smp;
      end
      default: begin
        cnt_d = '0;
        lvl_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl = lvl_q;

  // A parked filter shows a low output and an empty count one edge later.
  AST_OFF_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (lvl_q == 1'b0) && (cnt_q == '0)); // R6

  // The run never reaches the longest window without having flipped.
  AST_CNT_BELOW_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_LEN)); // R3

  // A sample equal to the output throws the run away.
  AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (smp == lvl_q)) |=> (cnt_q == '0)); // R4

  // A run shorter than the length leaves the output alone.
  AST_SHORT_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (smp != lvl_q) && (cnt_inc < run_len)) |=> $stable(lvl_q)); // R2

  // Once the run covers the present length, the output follows at once.
  AST_FULL_RUN_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (smp != lvl_q) && (cnt_inc >= run_len)) |=> (lvl_q == $past(smp))); // R7

endmodule

// File: rtl/lvl_debounce.sv
module lvl_debounce
  import dbf_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CODE_W      = 3,
  parameter int unsigned LONG_LEN    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              raw_in,
  input  logic [CODE_W-1:0] len_code,
  output logic              clean_out
);

  localparam int unsigned CNT_W = cnt_width(LONG_LEN);

  logic             smp;
  logic [CNT_W-1:0] run_len;

  dbf_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_in),
    .q_sync  (smp)
  );

  dbf_len_decode #(
    .CODE_W   (CODE_W),
    .LONG_LEN (LONG_LEN),
    .CNT_W    (CNT_W)
  ) u_len (
    .len_code (len_code),
    .run_len  (run_len)
  );

  dbf_stab_counter #(
    .MAX_LEN (LONG_LEN),
    .CNT_W   (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .smp     (smp),
    .run_len (run_len),
    .lvl     (clean_out)
  );

  // The decoded length always lies between one sample and the long window.
  always_comb begin
    AST_LEN_IN_RANGE: assert ((run_len >= CNT_W'(1)) && (run_len <= CNT_W'(LONG_LEN))); // R2
  end

endmodule

// File: tb/sim_lvl_debounce.sv
module sim_lvl_debounce;

  localparam int CLK_PERIOD = 10;
  localparam int LONG_LEN   = 16;
  localparam int SETTLE     = LONG_LEN + 6;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic       raw;
  logic [2:0] code;
  logic       clean;

  int    vectors;
  int    miscompares;
  string phase;
  bit    done;
  bit    hi_seen;
  bit    lo_seen;

  // Behavioural reference state.
  int m_pipe[$];
  int m_run;
  int m_lvl;
  int m_s;

  lvl_debounce u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .raw_in    (raw),
    .len_code  (code),
    .clean_out (clean)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int len_of(input int c);
    return (c == 7) ? 16 : c + 1;
  endfunction

  // Reference: a two-entry delay queue, then a run counter.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pipe = {0, 0};
      m_run  = 0;
      m_lvl  = 0;
    end else begin
      m_s = m_pipe.pop_front();
      m_pipe.push_back(int'(raw));
      if (!en) begin
        m_run = 0;
        m_lvl = 0;
      end else if (m_s == m_lvl) begin
        m_run = 0;
      end else if (m_run + 1 >= len_of(int'(code))) begin
        m_lvl = m_s;
        m_run = 0;
      end else begin
        m_run = m_run + 1;
      end
    end
  end

  // Compare with the reference on every falling edge.
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (int'(clean) != m_lvl) begin
        miscompares++;
        $display("FAIL %s: clean_out=%0b expected %0d at %0t", phase, clean, m_lvl, $time);
      end
      if (clean) hi_seen = 1'b1;
      else       lo_seen = 1'b1;
    end
  end

  task automatic check(input string req, input bit act, input bit exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Excursion of w samples away from the settled level base, then settle.
  task automatic excursion(input int w, input bit base);
    hi_seen = 1'b0;
    lo_seen = 1'b0;
    raw = ~base;
    wait_n(w);
    raw = base;
    wait_n(SETTLE);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    vectors = 0; miscompares = 0; done = 1'b0;
    hi_seen = 1'b0; lo_seen = 1'b0;
    phase = "R1";
    rst_n = 1'b0; en = 1'b1; raw = 1'b1; code = 3'd0;
    wait_n(4);
    check("R1 output low in reset", clean, 1'b0);
    raw = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    check("R1 output low after release", clean, 1'b0);

    // R5: two synchroniser edges, then the code-0 flip.
    phase = "R5";
    code = 3'd0;
    raw = 1'b1;
    wait_n(2);
    check("R5 not yet through synchroniser", clean, 1'b0);
    wait_n(1);
    check("R5 code 0 follows at third edge", clean, 1'b1);
    raw = 1'b0;
    wait_n(SETTLE);

    // R2: each short code, one sample short and exactly long enough.
    phase = "R2";
    for (int c = 0; c < 7; c++) begin
      code = 3'(c);
      if (len_of(c) > 1) begin
        excursion(len_of(c) - 1, 1'b0);
        check($sformatf("R2 code %0d short pulse dropped", c), hi_seen, 1'b0);
      end
      excursion(len_of(c), 1'b0);
      check($sformatf("R2 code %0d full pulse passes", c), hi_seen, 1'b1);
    end

    // R3: the long window at code 7.
    phase = "R3";
    code = 3'd7;
    excursion(15, 1'b0);
    check("R3 fifteen samples dropped", hi_seen, 1'b0);
    excursion(16, 1'b0);
    check("R3 sixteen samples pass", hi_seen, 1'b1);

    // R4: low excursions from a settled high output.
    phase = "R4";
    code = 3'd3;
    raw = 1'b1;
    wait_n(SETTLE);
    check("R4 settled high", clean, 1'b1);
    excursion(3, 1'b1);
    check("R4 three-sample dip dropped", lo_seen, 1'b0);
    excursion(4, 1'b1);
    check("R4 four-sample dip passes", lo_seen, 1'b1);
    code = 3'd1;
    lo_seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      raw = ~raw;
      wait_n(1);
    end
    raw = 1'b1;
    wait_n(SETTLE);
    check("R4 single-sample chatter dropped", lo_seen, 1'b0);

    // R6: disable parks the output low and ignores the input.
    phase = "R6";
    en = 1'b0;
    wait_n(1);
    check("R6 disable forces low", clean, 1'b0);
    hi_seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      raw = (i % 3 != 0);
      wait_n(1);
    end
    raw = 1'b1;
    wait_n(4);
    check("R6 input ignored while disabled", hi_seen, 1'b0);
    code = 3'd4;
    en = 1'b1;
    wait_n(4);
    check("R6 re-enable needs full run", clean, 1'b0);
    wait_n(1);
    check("R6 high after five enabled samples", clean, 1'b1);
    raw = 1'b0;
    wait_n(SETTLE);

    // R7: shortening the length in the middle of a run.
    phase = "R7";
    code = 3'd6;
    raw = 1'b1;
    wait_n(6);
    check("R7 still counting at old length", clean, 1'b0);
    code = 3'd1;
    wait_n(1);
    check("R7 new length applies next sample", clean, 1'b1);
    raw = 1'b0;
    wait_n(SETTLE);

    // Mixed traffic compared against the reference on every cycle.
    phase = "R2/R4/R6/R7 random runs";
    for (int k = 0; k < 600; k++) begin
      raw = ~raw;
      if ($urandom_range(0, 9) == 0) code = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 39) == 0) en = ~en;
      wait_n(int'($urandom_range(1, 20)));
    end
    en = 1'b1;
    wait_n(SETTLE);

    finish_run();
  end

endmodule